// File: doc/BRIEF.md
# Chainable Serial Result Shifter

This block is the slave-side serial readout of a 16-bit converter result. A finished conversion is signalled by the busy input falling. At that edge the parallel result is latched as the current word. While chip select is low, an externally supplied serial clock shifts that word out of the serial data pin, most significant bit first. The pin is driven only while chip select and read enable are both low.

A chain input allows several devices to share one serial data line. The block samples the chain input on the serial clock edge opposite the one that advances the output, and feeds the sampled bits in behind the local word. When the chain input of one device is tied to the serial output of a second device, the local LSB is followed by the second device's MSB on the very next serial clock, with no gap. With a shared chip select and serial clock, 32 pulses read two chained devices.

The serial clock is oversampled by the system clock `clk_i`. It may be free-running or gated, and it may idle at either level.

Top module: `serial_result_chain`

## Requirements
- R1: While `rst_ni` is low, `sdo_oe_o` and `sdo_o` are 0 and the held word is cleared to zero.
- R2: `sdo_oe_o` is 1 exactly when `cs_ni` and `rd_ni` are both 0. Whenever `sdo_oe_o` is 0, `sdo_o` is 0.
- R3: A falling edge of `busy_i` while `cs_ni` is 1 latches `result_i`. Bit 15 of that word is on `sdo_o` as soon as output is enabled, from the second `clk_i` edge after the edge at which the fall is seen.
- R4: With `sclk_inv_i` = 0, each falling edge of `sclk_i` that is seen during a read advances `sdo_o` to the next lower bit. The new bit is valid from the first `clk_i` edge that samples the new `sclk_i` level. The 16 local bits leave MSB first.
- R5: `sdi_i` is sampled on each rising edge of `sclk_i` (with `sclk_inv_i` = 0). After the 16 local bits, `sdo_o` carries the sampled chain bits in arrival order. The chained device's MSB occupies bit slot 17 with no gap cycle.
- R6: The chain bit is cleared whenever `cs_ni` is high. If the chain input stays 0, every bit after the local word reads 0.
- R7: With `sclk_inv_i` = 1, the two edges swap roles: rising edges advance `sdo_o` and falling edges sample `sdi_i`.
- R8: Serial clock edges are ignored (no shift and no chain sample) while `ext_clk_i` is 0 or `busy_i` is 1.
- R9: A falling edge of `busy_i` while `cs_ni` is 0 does not disturb the read in progress. The new word is held and takes effect once `cs_ni` is high.
- R10: While `cs_ni` is 1, the shift register is reloaded from the held word, so each new read restarts at bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External serial clock mode select; 1 enables shifting |
| sclk_i | input | 1 | External serial clock, synchronous to clk_i |
| sclk_inv_i | input | 1 | Swaps the drive and sample edges when 1; change only while cs_ni is 1 |
| cs_ni | input | 1 | Active-low chip select; also gates the serial clock |
| rd_ni | input | 1 | Active-low read enable |
| busy_i | input | 1 | High during conversion; the falling edge marks a new result |
| result_i | input | W (16) | Parallel conversion result |
| sdi_i | input | 1 | Chain input from the upstream device |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (0 means high impedance) |

## Verification
Every serial clock change is applied at a falling edge of `clk_i`. The resulting output bit is registered at the next rising edge, so the bench reads it two system cycles later, just before it issues the next pulse. A busy fall updates the held word one edge later, and the shift register takes that word one edge after that. The bench therefore lowers chip select and samples the MSB two cycles after the fall. Output enable is combinational on chip select and read enable, so it is checked one time step after those inputs change. The deferred-load test reads the tail of the old word before raising chip select and reading the new word.

// File: rtl/src_pkg.sv
package src_pkg;
  typedef struct packed {
    logic drive;   // advance serial output
    logic sample;  // capture chain input
  } sclk_ev_t;
endpackage

// File: rtl/src_sclk_edge.sv
module src_sclk_edge
  import src_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sclk_i,
  input  logic     inv_i,
  input  logic     en_i,
  output sclk_ev_t ev_o
);
  logic lvl, lvl_q;

  assign lvl = sclk_i ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl;
  end

  assign ev_o.drive  = en_i &  lvl_q & ~lvl;
  assign ev_o.sample = en_i & ~lvl_q &  lvl;
endmodule

// File: rtl/src_word_load.sv
module src_word_load #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         busy_i,
  input  logic         cs_ni,
  input  logic [W-1:0] result_i,
  output logic [W-1:0] word_o
);
  logic         busy_q, pend_q, fall;
  logic [W-1:0] hold_q, word_q;

  assign fall = busy_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      hold_q <= '0;
      word_q <= '0;
    end else begin
      busy_q <= busy_i;
      if (fall && cs_ni) begin
        word_q <= result_i;
        pend_q <= 1'b0;
      end else if (fall) begin
        hold_q <= result_i;   // read in progress: defer
        pend_q <= 1'b1;
      end else if (pend_q && cs_ni) begin
        word_q <= hold_q;
        pend_q <= 1'b0;
      end
    end
  end

  assign word_o = word_q;

  a_r3_load_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && cs_ni) |=> word_q == $past(result_i));
  a_r9_no_load_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !cs_ni) |=> $stable(word_q));
  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cs_ni && !fall) |=> (word_q == $past(hold_q)) && !pend_q);
endmodule

// File: rtl/src_shift_chain.sv
module src_shift_chain
  import src_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic [W-1:0] word_i,
  input  sclk_ev_t     ev_i,
  input  logic         sdi_i,
  output logic         msb_o
);
  logic [W-1:0] sreg_q;
  logic         chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q  <= '0;
      chain_q <= 1'b0;
    end else if (cs_ni) begin
      sreg_q  <= word_i;
      chain_q <= 1'b0;
    end else begin
      if (ev_i.sample) chain_q <= sdi_i;
      if (ev_i.drive)  sreg_q  <= {sreg_q[W-2:0], chain_q};
    end
  end

  assign msb_o = sreg_q[W-1];

  a_r4_next_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && ev_i.drive) |=> msb_o == $past(sreg_q[W-2]));
  a_r8_hold_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !ev_i.drive) |=> $stable(sreg_q));
  a_r10_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> sreg_q == $past(word_i));
  a_r6_chain_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !chain_q);
endmodule

// File: rtl/serial_result_chain.sv
module serial_result_chain
  import src_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ext_clk_i,
  input  logic         sclk_i,
  input  logic         sclk_inv_i,
  input  logic         cs_ni,
  input  logic         rd_ni,
  input  logic         busy_i,
  input  logic [W-1:0] result_i,
  input  logic         sdi_i,
  output logic         sdo_o,
  output logic         sdo_oe_o
);
  logic         rd_en, shift_en, msb;
  logic [W-1:0] word;
  sclk_ev_t     ev;

  assign rd_en    = ~cs_ni & ~rd_ni;
  assign shift_en = rd_en & ext_clk_i & ~busy_i;

  src_sclk_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .inv_i  (sclk_inv_i),
    .en_i   (shift_en),
    .ev_o   (ev)
  );

  src_word_load #(.W(W)) u_load (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy_i),
    .cs_ni    (cs_ni),
    .result_i (result_i),
    .word_o   (word)
  );

  src_shift_chain #(.W(W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .word_i (word),
    .ev_i   (ev),
    .sdi_i  (sdi_i),
    .msb_o  (msb)
  );

  assign sdo_oe_o = rd_en;
  assign sdo_o    = rd_en & msb;

  a_r8_gated_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_clk_i || busy_i) |-> (ev == '0));
endmodule

// File: tb/test_serial_result_chain.sv
module test_serial_result_chain;
  typedef struct packed {
    logic [15:0] dn;
    logic [15:0] up;
    logic        inv;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{16'hA5C3, 16'h3C5A, 1'b0},
    '{16'hFFFF, 16'h0001, 1'b1},
    '{16'h8001, 16'h7FFE, 1'b0},
    '{16'h1234, 16'hFEDC, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni, ext_clk, sclk, inv, cs_n, rd_n, busy;
  logic [15:0] res_dn, res_up;
  logic sdo_dn, oe_dn, sdo_up, oe_up;
  logic s_lvl;
  int   n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  serial_result_chain #(.W(16)) i_serial_result_chain (
    .clk_i(clk), .rst_ni(rst_ni), .ext_clk_i(ext_clk), .sclk_i(sclk),
    .sclk_inv_i(inv), .cs_ni(cs_n), .rd_ni(rd_n), .busy_i(busy),
    .result_i(res_dn), .sdi_i(sdo_up), .sdo_o(sdo_dn), .sdo_oe_o(oe_dn)
  );

  serial_result_chain #(.W(16)) i_upstream (
    .clk_i(clk), .rst_ni(rst_ni), .ext_clk_i(ext_clk), .sclk_i(sclk),
    .sclk_inv_i(inv), .cs_ni(cs_n), .rd_ni(rd_n), .busy_i(busy),
    .result_i(res_up), .sdi_i(1'b0), .sdo_o(sdo_up), .sdo_oe_o(oe_up)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_s(input logic v);
    s_lvl = v;
    sclk  = v ^ inv;
  endtask

  // sample edge, then drive edge
  task automatic pulse();
    set_s(1'b1); tick(2);
    set_s(1'b0); tick(2);
  endtask

  task automatic load(input logic [15:0] d, input logic [15:0] u);
    cs_n = 1'b1; res_dn = d; res_up = u;
    busy = 1'b1; tick(2);
    busy = 1'b0; tick(3);
  endtask

  task automatic read_n(input int n, output logic [63:0] acc);
    acc = '0;
    for (int i = 0; i < n; i++) begin
      acc = {acc[62:0], sdo_dn};
      pulse();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] acc;
    rst_ni = 1'b0; ext_clk = 1'b1; inv = 1'b0; cs_n = 1'b1; rd_n = 1'b0;
    busy = 1'b0; res_dn = '0; res_up = '0;
    set_s(1'b0);
    tick(3);
    check("R1 oe", {63'd0, oe_dn}, 64'd0);
    check("R1 sdo", {63'd0, sdo_dn}, 64'd0);
    rst_ni = 1'b1; tick(2);
    cs_n = 1'b0; tick(1);
    check("R1 cleared word", {63'd0, sdo_dn}, 64'd0);
    cs_n = 1'b1; tick(2);

    // table: two chained devices, 33 bit slots
    for (int v = 0; v < NV; v++) begin
      inv = VECS[v].inv; set_s(1'b0); tick(2);
      load(VECS[v].dn, VECS[v].up);
      cs_n = 1'b0; tick(1);
      read_n(33, acc);
      check(VECS[v].inv ? "R7 R5 chained word" : "R4 R5 chained word",
            {32'd0, acc[32:1]}, {32'd0, VECS[v].dn, VECS[v].up});
      check("R6 tail low", {63'd0, acc[0]}, 64'd0);
      cs_n = 1'b1; tick(2);
    end
    inv = 1'b0; set_s(1'b0); tick(2);

    // R3: latency of busy fall to MSB
    cs_n = 1'b1; res_dn = 16'h8000; busy = 1'b1; tick(2);
    busy = 1'b0; tick(2);
    cs_n = 1'b0; #1;
    check("R3 msb after busy fall", {63'd0, sdo_dn}, 64'd1);
    tick(1);

    // R2: output enable
    load(16'hA001, 16'h0000);
    cs_n = 1'b0; rd_n = 1'b1; #1;
    check("R2 oe off rd high", {63'd0, oe_dn}, 64'd0);
    check("R2 sdo low rd high", {63'd0, sdo_dn}, 64'd0);
    tick(1);
    rd_n = 1'b0; #1;
    check("R2 oe on", {63'd0, oe_dn}, 64'd1);
    check("R3 msb first", {63'd0, sdo_dn}, 64'd1);
    tick(1);

    // R8: ext clock mode off
    ext_clk = 1'b0; pulse();
    check("R8 ext off ignored", {63'd0, sdo_dn}, 64'd1);
    ext_clk = 1'b1; pulse();
    check("R4 bit14", {63'd0, sdo_dn}, 64'd0);

    // R10: restart
    cs_n = 1'b1; tick(2); cs_n = 1'b0; tick(1);
    check("R10 restart msb", {63'd0, sdo_dn}, 64'd1);

    // R9: deferred load, R8 busy gating
    pulse(); pulse();
    check("R4 bit13", {63'd0, sdo_dn}, 64'd1);
    res_dn = 16'h5FFE; busy = 1'b1; tick(2);
    pulse();
    check("R8 busy ignored", {63'd0, sdo_dn}, 64'd1);
    busy = 1'b0; tick(3);
    read_n(14, acc);
    check("R9 old word kept", {50'd0, acc[13:0]}, {50'd0, 14'h2001});
    cs_n = 1'b1; tick(3); cs_n = 1'b0; tick(1);
    read_n(16, acc);
    check("R9 deferred word", {48'd0, acc[15:0]}, {48'd0, 16'h5FFE});
    cs_n = 1'b1; tick(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule